// File: doc/BRIEF.md
# Breaker Fault Latch with Qualified Clear

This block turns the sampled output of an overcurrent comparator into a latched breaker fault. A trip is accepted only when the overcurrent flag stays high for longer than a persistence window, so short spikes never set the fault. After it is set, the fault stays set even when the current returns to normal, until one of two clear conditions is met.

The first clear condition is a reset input held low long enough. Only low time with no overcurrent counts toward this limit, so the pulse must come after the excess current has gone. The second clear condition is an undervoltage lockout held long enough. It works on its own, with no need for the reset input.

All three windows are counted in clock cycles. They are derived from a clock-rate parameter and from microsecond parameters. A one-cycle event pulse marks each new trip.

Top module: `breaker_fault_latch`

## Requirements
- R1: While `rstN` is low, `faultLatched` and `tripPulse` are 0.
- R2: An overcurrent run of TRIP_CYC or fewer consecutive samples never sets the fault. Any sample with `overCurrent` low restarts the run.
- R3: On the (TRIP_CYC+1)th consecutive sample with `overCurrent` high, `faultLatched` becomes 1 after that clock edge.
- R4: `tripPulse` is high for exactly one cycle, in the same cycle that `faultLatched` rises. It does not pulse while the fault is already set.
- R5: Once set, the fault stays set after `overCurrent` returns low, as long as no clear condition is met.
- R6: The fault clears on the (CLEAR_CYC+1)th consecutive sample with `resetPinLow` high and `overCurrent` low. CLEAR_CYC such samples are not enough.
- R7: A sample with `overCurrent` high restarts the reset-pin count. Low time taken while overcurrent is present never counts.
- R8: The fault clears on the (LOCK_CYC+1)th consecutive sample with `lockout` high, whatever `overCurrent` is doing. LOCK_CYC such samples are not enough.
- R9: If a trip qualifies in the same cycle as a clear, the fault ends up set.
- R10: The window lengths are TRIP_CYC = CLK_MHZ*TRIP_US, CLEAR_CYC = CLK_MHZ*CLEAR_US and LOCK_CYC = CLK_MHZ*LOCK_US. The defaults are 1 µs, 150 µs and 10 µs. A reset-pin low pulse of 50 µs never clears the fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| overCurrent | input | 1 | Digitised flag: current above the trip level |
| resetPinLow | input | 1 | Digitised flag: reset input below its threshold |
| lockout | input | 1 | Digitised flag: supply in undervoltage lockout |
| faultLatched | output | 1 | Breaker fault state |
| tripPulse | output | 1 | One-cycle pulse on each new trip |

## Verification
Both outputs are registered one edge after the input sample that decides them. A trip is therefore visible right after the edge that samples the (TRIP_CYC+1)th high cycle, and a clear right after the edge that samples the (limit+1)th qualifying cycle. The bench changes inputs on falling edges and reads the outputs on the next falling edge. It runs each window to exactly its limit and to one sample past it, and checks the outputs at those points.

// File: rtl/bfl_pkg.sv
package bfl_pkg;

  // Index of each run timer inside the datapath
  localparam int unsigned IDX_OC = 0;
  localparam int unsigned IDX_RP = 1;
  localparam int unsigned IDX_LK = 2;
  localparam int unsigned NUM_TIMERS = 3;

  // Control -> datapath: which run timers advance this cycle
  typedef struct packed {
    logic ocAdvance;
    logic rpAdvance;
    logic lkAdvance;
  } bfl_strobe_t;

  // Datapath -> control: which run timers have reached their limit
  typedef struct packed {
    logic ocAtLimit;
    logic rpAtLimit;
    logic lkAtLimit;
  } bfl_limit_t;

endpackage

// File: rtl/bfl_run_timer.sv
module bfl_run_timer #(
  parameter int unsigned LIMIT = 10,
  parameter int unsigned CNT_W = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic advance,
  output logic atLimit
);

  logic [CNT_W-1:0] runCount;
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

  // Counts consecutive advancing cycles, saturating at LIMIT; any idle cycle restarts it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCount <= '0;
    end else if (!advance) begin
      runCount <= '0;
    end else if (runCount != LIMIT_V) begin
      runCount <= runCount + 1'b1;
    end
  end

  assign atLimit = (runCount == LIMIT_V);

  // An idle cycle always restarts the run (R2, R7)
  assert_run_restarts_R7: assert property (@(posedge clk) disable iff (!rstN)
    !advance |=> (runCount == '0));

  // The count never passes its limit (R2)
  assert_count_bounded_R2: assert property (@(posedge clk) disable iff (!rstN)
    runCount <= LIMIT_V);

endmodule

// File: rtl/bfl_datapath.sv
module bfl_datapath
  import bfl_pkg::*;
#(
  parameter int unsigned TRIP_CYC  = 10,
  parameter int unsigned CLEAR_CYC = 1500,
  parameter int unsigned LOCK_CYC  = 100
) (
  input  logic        clk,
  input  logic        rstN,
  input  bfl_strobe_t strobe,
  output bfl_limit_t  limit
);

  localparam int unsigned MAX_A   = (TRIP_CYC > CLEAR_CYC) ? TRIP_CYC : CLEAR_CYC;
  localparam int unsigned MAX_CYC = (MAX_A > LOCK_CYC) ? MAX_A : LOCK_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic [NUM_TIMERS-1:0] advVec;
  logic [NUM_TIMERS-1:0] limVec;

  assign advVec[IDX_OC] = strobe.ocAdvance;
  assign advVec[IDX_RP] = strobe.rpAdvance;
  assign advVec[IDX_LK] = strobe.lkAdvance;

  function automatic int unsigned limitFor(input int unsigned idx);
    case (idx)
      IDX_OC:  return TRIP_CYC;
      IDX_RP:  return CLEAR_CYC;
      default: return LOCK_CYC;
    endcase
  endfunction

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : gTimer
    bfl_run_timer #(
      .LIMIT(limitFor(g)),
      .CNT_W(CNT_W)
    ) timer_i (
      .clk    (clk),
      .rstN   (rstN),
      .advance(advVec[g]),
      .atLimit(limVec[g])
    );
  end

  assign limit.ocAtLimit = limVec[IDX_OC];
  assign limit.rpAtLimit = limVec[IDX_RP];
  assign limit.lkAtLimit = limVec[IDX_LK];

endmodule

// File: rtl/bfl_control.sv
module bfl_control
  import bfl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        overCurrent,
  input  logic        resetPinLow,
  input  logic        lockout,
  input  bfl_limit_t  limit,
  output bfl_strobe_t strobe,
  output logic        faultLatched,
  output logic        tripPulse
);

  logic tripQual;
  logic pinClearQual;
  logic lockClearQual;
  logic clearQual;
  logic latchNext;

  // Only reset-pin low time free of overcurrent advances the clear window
  always_comb begin
    strobe.ocAdvance = overCurrent;
    strobe.rpAdvance = resetPinLow && !overCurrent;
    strobe.lkAdvance = lockout;
  end

  assign tripQual      = strobe.ocAdvance && limit.ocAtLimit;
  assign pinClearQual  = strobe.rpAdvance && limit.rpAtLimit;
  assign lockClearQual = strobe.lkAdvance && limit.lkAtLimit;
  assign clearQual     = pinClearQual || lockClearQual;

  // Set has priority over either clear path
  always_comb begin
    if (tripQual)       latchNext = 1'b1;
    else if (clearQual) latchNext = 1'b0;
    else                latchNext = faultLatched;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultLatched <= 1'b0;
      tripPulse    <= 1'b0;
    end else begin
      faultLatched <= latchNext;
      tripPulse    <= tripQual && !faultLatched;
    end
  end

  assert_rise_needs_overcurrent_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultLatched) |-> ($past(overCurrent) && $past(limit.ocAtLimit)));

  assert_fall_needs_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(faultLatched) |-> ($past(lockout) || ($past(resetPinLow) && !$past(overCurrent))));

  assert_hold_without_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (faultLatched && !resetPinLow && !lockout) |=> faultLatched);

  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    tripPulse |=> !tripPulse);

  assert_pulse_marks_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    tripPulse |-> (faultLatched && !$past(faultLatched)));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (overCurrent && limit.ocAtLimit) |=> faultLatched);

endmodule

// File: rtl/breaker_fault_latch.sv
module breaker_fault_latch
  import bfl_pkg::*;
#(
  parameter int unsigned CLK_MHZ  = 10,
  parameter int unsigned TRIP_US  = 1,
  parameter int unsigned CLEAR_US = 150,
  parameter int unsigned LOCK_US  = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic overCurrent,
  input  logic resetPinLow,
  input  logic lockout,
  output logic faultLatched,
  output logic tripPulse
);

  // Window lengths in cycles (R10)
  localparam int unsigned TRIP_CYC  = CLK_MHZ * TRIP_US;
  localparam int unsigned CLEAR_CYC = CLK_MHZ * CLEAR_US;
  localparam int unsigned LOCK_CYC  = CLK_MHZ * LOCK_US;

  bfl_strobe_t strobe;
  bfl_limit_t  limit;

  bfl_datapath #(
    .TRIP_CYC (TRIP_CYC),
    .CLEAR_CYC(CLEAR_CYC),
    .LOCK_CYC (LOCK_CYC)
  ) datapath_i (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .limit (limit)
  );

  bfl_control control_i (
    .clk         (clk),
    .rstN        (rstN),
    .overCurrent (overCurrent),
    .resetPinLow (resetPinLow),
    .lockout     (lockout),
    .limit       (limit),
    .strobe      (strobe),
    .faultLatched(faultLatched),
    .tripPulse   (tripPulse)
  );

endmodule

// File: tb/breaker_fault_latch_tb.sv
module breaker_fault_latch_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_MHZ    = 10;
  localparam int TRIP       = CLK_MHZ * 1;
  localparam int CLR        = CLK_MHZ * 150;
  localparam int LCK        = CLK_MHZ * 10;
  localparam int SHORT_PIN  = CLK_MHZ * 50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic overCurrent = 1'b0;
  logic resetPinLow = 1'b0;
  logic lockout = 1'b0;
  logic faultLatched;
  logic tripPulse;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  breaker_fault_latch #(.CLK_MHZ(CLK_MHZ)) dut_i (
    .clk         (clk),
    .rstN        (rstN),
    .overCurrent (overCurrent),
    .resetPinLow (resetPinLow),
    .lockout     (lockout),
    .faultLatched(faultLatched),
    .tripPulse   (tripPulse)
  );

  typedef struct packed {
    logic        oc;
    logic        rl;
    logic        lk;
    logic [31:0] n;
    logic        expF;
    logic        expP;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b0, 32'(TRIP),    1'b0, 1'b0, 8'd2},
    '{1'b0, 1'b0, 1'b0, 32'd1,        1'b0, 1'b0, 8'd2},
    '{1'b1, 1'b0, 1'b0, 32'(TRIP),    1'b0, 1'b0, 8'd2},
    '{1'b1, 1'b0, 1'b0, 32'd1,        1'b1, 1'b1, 8'd3},
    '{1'b1, 1'b0, 1'b0, 32'd3,        1'b1, 1'b0, 8'd4},
    '{1'b0, 1'b0, 1'b0, 32'd20,       1'b1, 1'b0, 8'd5},
    '{1'b0, 1'b1, 1'b0, 32'(CLR),     1'b1, 1'b0, 8'd6},
    '{1'b0, 1'b0, 1'b0, 32'd1,        1'b1, 1'b0, 8'd6},
    '{1'b0, 1'b1, 1'b0, 32'(CLR+1),   1'b0, 1'b0, 8'd6},
    '{1'b0, 1'b0, 1'b0, 32'd2,        1'b0, 1'b0, 8'd6},
    '{1'b1, 1'b0, 1'b0, 32'(TRIP+1),  1'b1, 1'b1, 8'd3},
    '{1'b1, 1'b1, 1'b0, 32'(CLR+5),   1'b1, 1'b0, 8'd7},
    '{1'b0, 1'b1, 1'b0, 32'(CLR),     1'b1, 1'b0, 8'd7},
    '{1'b0, 1'b1, 1'b0, 32'd1,        1'b0, 1'b0, 8'd7},
    '{1'b0, 1'b0, 1'b0, 32'd1,        1'b0, 1'b0, 8'd7},
    '{1'b1, 1'b0, 1'b0, 32'(TRIP+1),  1'b1, 1'b1, 8'd4},
    '{1'b0, 1'b0, 1'b0, 32'd1,        1'b1, 1'b0, 8'd5},
    '{1'b0, 1'b0, 1'b1, 32'(LCK),     1'b1, 1'b0, 8'd8},
    '{1'b0, 1'b0, 1'b0, 32'd1,        1'b1, 1'b0, 8'd8},
    '{1'b0, 1'b0, 1'b1, 32'(LCK+1),   1'b0, 1'b0, 8'd8},
    '{1'b0, 1'b0, 1'b0, 32'd1,        1'b0, 1'b0, 8'd8}
  };

  task automatic checkBit(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic checkOut(input string req, input logic expF, input logic expP);
    checkBit(req, "faultLatched", faultLatched, expF);
    checkBit(req, "tripPulse", tripPulse, expP);
  endtask

  // Inputs change on a falling edge; after the loop the next falling edge has been reached
  task automatic drive(input logic oc, input logic rl, input logic lk, input int n);
    for (int i = 0; i < n; i++) begin
      overCurrent = oc;
      resetPinLow = rl;
      lockout     = lk;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkOut("R1", 1'b0, 1'b0);   // reset state
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1", 1'b0, 1'b0);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      drive(VECS[v].oc, VECS[v].rl, VECS[v].lk, int'(VECS[v].n));
      checkOut($sformatf("R%0d", VECS[v].req), VECS[v].expF, VECS[v].expP);
    end

    // R10: a 50 us reset-pin pulse leaves the fault set
    drive(1'b1, 1'b0, 1'b0, TRIP + 1);
    checkOut("R10", 1'b1, 1'b1);
    drive(1'b0, 1'b0, 1'b0, 1);
    drive(1'b0, 1'b1, 1'b0, SHORT_PIN);
    checkOut("R10", 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1);
    checkOut("R10", 1'b1, 1'b0);

    // R8: lockout clears even when an overcurrent glitch is present
    drive(1'b0, 1'b0, 1'b1, LCK);
    checkOut("R8", 1'b1, 1'b0);
    drive(1'b1, 1'b0, 1'b1, 1);
    checkOut("R8", 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1);

    // R9: a qualified trip beats a qualified lockout clear
    drive(1'b1, 1'b0, 1'b0, TRIP + 1);
    checkOut("R9", 1'b1, 1'b1);
    drive(1'b1, 1'b0, 1'b1, LCK + 1);
    checkOut("R9", 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b1, 1);
    checkOut("R9", 1'b0, 1'b0);
    drive(1'b1, 1'b0, 1'b1, TRIP + 1);
    checkOut("R9", 1'b1, 1'b1);
    drive(1'b0, 1'b0, 1'b0, 1);

    // R1: reset in the middle of operation
    rstN = 1'b0;
    @(negedge clk);
    checkOut("R1", 1'b0, 1'b0);
    rstN = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 2);
    checkOut("R1", 1'b0, 1'b0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule